// File: doc/BRIEF.md
# JTAG Burst Shift Master

This block is a JTAG master driven from a host register bus. It works in bursts. The host fills a 128-bit TMS vector and a 128-bit outgoing data vector, each as four 32-bit words. It sets a TCK half-period divider and a burst length, then writes a go command. The engine then runs up to 128 TCK cycles toward the target device. Bit 0 of word 0 goes out first. The returning data line is captured into a 128-bit incoming vector.

When the last cycle ends, the block raises an interrupt. The host then reads the captured words back and prepares the next burst. Between bursts TCK stays low and TMS keeps its last value, so the target's TAP controller stays where the burst left it. The time from one burst to the next is set only by the host.

With a 40 MHz system clock, divider values from 20 to 200 give TCK rates from 1 MHz down to 100 kHz.

Top module: `jtag_burst_master`

Register map (word addresses): 0 to 3 hold the TMS words, 4 to 7 the outgoing data words, and 8 to 11 the captured words, which are read only. Address 12 is the divider and 13 the burst length. Address 14 is control and status: writing bit 0 = 1 is go; on read, bit 0 is busy and bit 1 is the interrupt. Address 15 acknowledges the interrupt. Read data is registered and appears one cycle after the read strobe.

## Requirements
- R1: After reset, TCK, TMS, the outgoing data line and the interrupt are low, the status word (address 14) reads 0, and the captured words read 0.
- R2: During TCK cycle i (i counts from 0), TMS carries bit i of the TMS vector and the outgoing line carries bit i of the outgoing vector. Bit i of vector word w is word w bit (i mod 32) with w = i/32. Both lines change only when TCK falls and are stable at every rising edge.
- R3: The incoming line is sampled when TCK rises in cycle i and stored in captured bit i, which is read at address 8 + i/32, bit i mod 32.
- R4: Each TCK high phase and each low phase inside a burst lasts exactly the divider value (address 12) in system clock cycles; a divider of 0 acts as 1.
- R5: A burst produces exactly N rising TCK edges, where N is the length register (address 13); a length of 0 acts as 1 and a length above 128 acts as 128.
- R6: Captured bits at positions N and above read as 0 after a burst.
- R7: Busy (status bit 0) is 1 from the accepted go until the last TCK falling edge; at that same edge the interrupt output and status bit 1 become 1, and they are never 1 while busy.
- R8: A go written while busy is ignored: the burst keeps its count and its data.
- R9: The interrupt is cleared by a write to address 15, by a read of address 15, or by an accepted go.
- R10: Between bursts TCK stays low and TMS holds the last bit driven in the previous burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (4) | Register word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data, valid the cycle after bus_rd |
| jtag_tck | output | 1 | Test clock to target |
| jtag_tms | output | 1 | Test mode select to target |
| jtag_do | output | 1 | Serial data toward target |
| jtag_di | input | 1 | Serial data returned by target |
| irq | output | 1 | Burst-complete interrupt, level |

## Verification
Bursts are run with these patterns:
- The shortest length at the fastest divider, to isolate the single rising and falling edge.
- A full 128-cycle burst at divider 2, to cover every word boundary in all three vectors.
- An odd length (37) at divider 3, so that a partial final word shows whether unused capture bits are cleared.
- Out-of-range settings (length 0, length 200, divider 0), to tell clamping apart from raw use.

Each TMS, outgoing and incoming pattern is a distinct word-dependent value. A swapped word, reversed bit order or off-by-one capture therefore gives a mismatch. Separate bursts then test a go written mid-burst and the three ways of clearing the interrupt.

// File: rtl/jtb_pkg.sv
package jtb_pkg;
  // status word bit positions (host visible)
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_IRQ_BIT  = 1;
  // control write: go request bit
  localparam int CTRL_GO_BIT   = 0;
  // region order in the word address space, in units of vector words
  localparam int REGION_TMS  = 0;
  localparam int REGION_DOUT = 1;
  localparam int REGION_DIN  = 2;
  localparam int REGION_CFG  = 3;
endpackage

// File: rtl/jtb_regs.sv
module jtb_regs
  import jtb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int DIV_W  = 16,
  parameter int LEN_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  input  logic [WORDS*DATA_W-1:0]  cap_vec,
  input  logic                     busy,
  input  logic                     irq,
  output logic [WORDS*DATA_W-1:0]  tms_vec,
  output logic [WORDS*DATA_W-1:0]  dout_vec,
  output logic [DIV_W-1:0]         div_cfg,
  output logic [LEN_W-1:0]         len_cfg,
  output logic                     start,
  output logic                     irq_clr
);
  localparam int DOUT_BASE = REGION_DOUT * WORDS;
  localparam int DIN_BASE  = REGION_DIN * WORDS;
  localparam int CFG_BASE  = REGION_CFG * WORDS;
  localparam logic [ADDR_W-1:0] DIV_A  = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] LEN_A  = ADDR_W'(CFG_BASE + 1);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CFG_BASE + 2);
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CFG_BASE + 3);

  logic [WORDS-1:0][DATA_W-1:0] tms_mem, dout_mem, cap_words;
  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] len_q;

  assign cap_words = cap_vec;
  assign tms_vec   = tms_mem;
  assign dout_vec  = dout_mem;
  assign div_cfg   = div_q;
  assign len_cfg   = len_q;
  assign start     = wr_en && (addr == CTRL_A) && wdata[CTRL_GO_BIT];
  assign irq_clr   = (wr_en || rd_en) && (addr == CLR_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      tms_mem  <= '0;
      dout_mem <= '0;
      div_q    <= '0;
      len_q    <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < WORDS; w++) begin
        if (addr == ADDR_W'(w))             tms_mem[w]  <= wdata;
        if (addr == ADDR_W'(DOUT_BASE + w)) dout_mem[w] <= wdata;
      end
      if (addr == DIV_A) div_q <= wdata[DIV_W-1:0];
      if (addr == LEN_A) len_q <= wdata[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      for (int w = 0; w < WORDS; w++) begin
        if (addr == ADDR_W'(w))             rdata <= tms_mem[w];
        if (addr == ADDR_W'(DOUT_BASE + w)) rdata <= dout_mem[w];
        if (addr == ADDR_W'(DIN_BASE + w))  rdata <= cap_words[w];
      end
      if (addr == DIV_A) rdata <= DATA_W'(div_q);
      if (addr == LEN_A) rdata <= DATA_W'(len_q);
      if (addr == CTRL_A) begin
        rdata[STAT_BUSY_BIT] <= busy;
        rdata[STAT_IRQ_BIT]  <= irq;
      end
    end
  end
endmodule

// File: rtl/jtb_tck_div.sv
module jtb_tck_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  // a zero divider acts as one
  assign last = (div_cfg == '0) ? '0 : div_cfg - DIV_W'(1);
  assign tick = run && !restart && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt_q <= '0;
    else if (cnt_q == last)     cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/jtb_engine.sv
module jtb_engine #(
  parameter int BITS  = 128,
  parameter int LEN_W = 8,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             irq_clr,
  input  logic             tick,
  input  logic [BITS-1:0]  tms_vec,
  input  logic [BITS-1:0]  dout_vec,
  input  logic [LEN_W-1:0] len_cfg,
  input  logic             di,
  output logic             accept,
  output logic             busy,
  output logic             tck,
  output logic             tms,
  output logic             dout,
  output logic [BITS-1:0]  cap_vec,
  output logic             irq
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_nxt;
  logic [LEN_W-1:0] len_q, len_eff;
  logic             last_bit;

  assign accept   = start && !busy;
  assign idx_nxt  = idx_q + IDX_W'(1);
  assign last_bit = ({1'b0, idx_q} == (len_q - LEN_W'(1)));

  always_comb begin
    if (len_cfg == '0)                  len_eff = LEN_W'(1);
    else if (len_cfg > LEN_W'(BITS))    len_eff = LEN_W'(BITS);
    else                                len_eff = len_cfg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      tck     <= 1'b0;
      tms     <= 1'b0;
      dout    <= 1'b0;
      idx_q   <= '0;
      len_q   <= LEN_W'(1);
      cap_vec <= '0;
      irq     <= 1'b0;
    end else if (accept) begin
      busy    <= 1'b1;
      irq     <= 1'b0;
      tck     <= 1'b0;
      idx_q   <= '0;
      len_q   <= len_eff;
      cap_vec <= '0;
      tms     <= tms_vec[0];
      dout    <= dout_vec[0];
    end else begin
      if (irq_clr) irq <= 1'b0;
      if (busy && tick) begin
        if (!tck) begin
          tck            <= 1'b1;
          cap_vec[idx_q] <= di;
        end else begin
          tck <= 1'b0;
          if (last_bit) begin
            busy <= 1'b0;
            irq  <= 1'b1;
          end else begin
            idx_q <= idx_nxt;
            tms   <= tms_vec[idx_nxt];
            dout  <= dout_vec[idx_nxt];
          end
        end
      end
    end
  end

  // R10
  tck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tck);
  // R10
  tms_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !accept) |=> $stable(tms));
  // R7
  irq_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy);
  // R7
  done_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $fell(busy));
  // R9
  go_clr_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!irq && busy));
  // R8
  busy_go_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !tick) |=> $stable(idx_q));
endmodule

// File: rtl/jtag_burst_master.sv
module jtag_burst_master #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              jtag_tck,
  output logic              jtag_tms,
  output logic              jtag_do,
  input  logic              jtag_di,
  output logic              irq
);
  localparam int BITS  = DATA_W * WORDS;
  localparam int IDX_W = $clog2(BITS);
  localparam int LEN_W = IDX_W + 1;

  logic [BITS-1:0]  tms_vec, dout_vec, cap_vec;
  logic [DIV_W-1:0] div_cfg;
  logic [LEN_W-1:0] len_cfg;
  logic start, irq_clr, accept, busy, tick;

  jtb_regs #(
    .DATA_W(DATA_W), .WORDS(WORDS), .DIV_W(DIV_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .cap_vec(cap_vec), .busy(busy),
    .irq(irq), .tms_vec(tms_vec), .dout_vec(dout_vec), .div_cfg(div_cfg),
    .len_cfg(len_cfg), .start(start), .irq_clr(irq_clr)
  );

  jtb_tck_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .restart(accept), .div_cfg(div_cfg),
    .tick(tick)
  );

  jtb_engine #(.BITS(BITS), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst(rst), .start(start), .irq_clr(irq_clr), .tick(tick),
    .tms_vec(tms_vec), .dout_vec(dout_vec), .len_cfg(len_cfg), .di(jtag_di),
    .accept(accept), .busy(busy), .tck(jtag_tck), .tms(jtag_tms),
    .dout(jtag_do), .cap_vec(cap_vec), .irq(irq)
  );
endmodule

// File: tb/jtag_burst_master_test.sv
module jtag_burst_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // length written, divider written, pattern seed
  localparam int unsigned VEC [NVEC][3] = '{
    '{1, 1, 3}, '{128, 2, 17}, '{37, 3, 41}, '{64, 1, 59}, '{0, 0, 71}, '{200, 1, 89}};

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic jtag_tck, jtag_tms, jtag_do, jtag_di, irq;

  int checks = 0, fails = 0, cyc = 0;
  int rise_cnt = 0, last_edge = -1, gap_min = 0, gap_max = 0;
  bit finished = 0;
  logic [127:0] tdi_pat = '0, obs_tms = '0, obs_do = '0;

  jtag_burst_master uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .jtag_tck(jtag_tck),
    .jtag_tms(jtag_tms), .jtag_do(jtag_do), .jtag_di(jtag_di), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // target model: presents incoming bit k until rising edge k has been seen
  assign jtag_di = tdi_pat[7'(rise_cnt)];
  always @(posedge jtag_tck) begin
    obs_tms[7'(rise_cnt)] = jtag_tms;
    obs_do[7'(rise_cnt)]  = jtag_do;
    rise_cnt++;
  end
  always @(jtag_tck) begin
    if (last_edge >= 0) begin
      if (cyc - last_edge < gap_min) gap_min = cyc - last_edge;
      if (cyc - last_edge > gap_max) gap_max = cyc - last_edge;
    end
    last_edge = cyc;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 4'(a);
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_irq(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      if (irq) begin ok = 1; return; end
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] pat_word(input int seed, input int w);
    logic [31:0] s = 32'(seed);
    return (s * 32'h0100_0193) ^ (32'h9E37_79B9 * 32'(w + 1)) ^ {s[15:0], 16'(w * 7 + 3)};
  endfunction

  task automatic run_burst(input int len_wr, input int div_wr, input int seed, input bit go_twice);
    int el = (len_wr == 0) ? 1 : (len_wr > 128 ? 128 : len_wr);
    int ed = (div_wr == 0) ? 1 : div_wr;
    logic [127:0] tms_b, do_b, di_b, cap, mask;
    logic [31:0] r;
    bit ok, irq_before;
    for (int w = 0; w < 4; w++) begin
      tms_b[w*32 +: 32] = pat_word(seed, w);
      do_b[w*32 +: 32]  = pat_word(seed + 5, w);
      di_b[w*32 +: 32]  = pat_word(seed + 9, w);
      bus_write(w, tms_b[w*32 +: 32]);
      bus_write(4 + w, do_b[w*32 +: 32]);
    end
    bus_write(12, 32'(div_wr));
    bus_write(13, 32'(len_wr));
    mask = (el >= 128) ? '1 : ((128'd1 << el) - 128'd1);
    tdi_pat = di_b; rise_cnt = 0; last_edge = -1; gap_min = 1000000; gap_max = 0;
    obs_tms = '0; obs_do = '0;
    irq_before = irq;
    bus_write(14, 32'h1);
    if (irq_before) chk(irq == 1'b0, "R9", "irq cleared by go", 128'(irq), 128'd0);
    if (go_twice) begin
      bus_read(14, r);
      chk(r[1:0] == 2'b01, "R7", "busy status mid-burst", 128'(r), 128'd1);
      bus_write(14, 32'h1);
    end
    wait_irq(ok);
    chk(ok, "R7", "irq at burst end", 128'(ok), 128'd1);
    chk(rise_cnt == el, go_twice ? "R8" : "R5", "rising edge count", 128'(rise_cnt), 128'(el));
    chk((obs_tms & mask) == (tms_b & mask), "R2", "TMS sequence", obs_tms & mask, tms_b & mask);
    chk((obs_do & mask) == (do_b & mask), "R2", "data-out sequence", obs_do & mask, do_b & mask);
    chk(gap_min == ed && gap_max == ed, "R4", "half-period",
        128'({gap_min[15:0], gap_max[15:0]}), 128'({ed[15:0], ed[15:0]}));
    for (int w = 0; w < 4; w++) begin
      bus_read(8 + w, r);
      cap[w*32 +: 32] = r;
    end
    chk((cap & mask) == (di_b & mask), go_twice ? "R8" : "R3", "captured bits", cap & mask, di_b & mask);
    chk((cap & ~mask) == '0, "R6", "unused capture bits", cap & ~mask, 128'd0);
    bus_read(14, r);
    chk(r[1:0] == 2'b10, "R7", "status after burst", 128'(r), 128'd2);
    repeat (3 * ed + 4) @(negedge clk);
    chk(jtag_tck == 1'b0 && jtag_tms == tms_b[el-1] && rise_cnt == el, "R10", "idle hold",
        128'({jtag_tck, jtag_tms}), 128'({1'b0, tms_b[el-1]}));
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired", 128'd1, 128'd0);
    summary();
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({jtag_tck, jtag_tms, jtag_do, irq} == 4'b0, "R1", "outputs after reset",
        128'({jtag_tck, jtag_tms, jtag_do, irq}), 128'd0);
    bus_read(14, r);
    chk(r == 32'd0, "R1", "status after reset", 128'(r), 128'd0);
    bus_read(8, r);
    chk(r == 32'd0, "R1", "capture after reset", 128'(r), 128'd0);

    for (int i = 0; i < NVEC; i++)
      run_burst(int'(VEC[i][0]), int'(VEC[i][1]), int'(VEC[i][2]), 1'b0);

    // R8: go repeated mid-burst must not restart it
    run_burst(40, 2, 101, 1'b1);

    // R9: clear by write
    bus_write(15, 32'h0);
    chk(irq == 1'b0, "R9", "irq cleared by write", 128'(irq), 128'd0);
    bus_read(14, r);
    chk(r[1] == 1'b0, "R9", "status irq after write clear", 128'(r), 128'd0);

    // R9: clear by read
    run_burst(5, 1, 113, 1'b0);
    bus_read(15, r);
    chk(irq == 1'b0, "R9", "irq cleared by read", 128'(irq), 128'd0);

    summary();
  end
endmodule